// File: doc/BRIEF.md
# Turn-Aligned Trigger Generator

This block produces two start pulses for a beam-measurement front end: an acquisition trigger that starts a data frame and an excitation trigger that starts the stimulus. It counts a programmable number of ticks from a selectable timing source before the first acquisition trigger. The source is either a millisecond tick or a once-per-turn tick. It then waits for the next turn tick and issues the pulse on the first sample enable at or after that tick. Every trigger therefore sits on a sample boundary and on a turn boundary. The relative timing of acquisition and excitation is free of jitter.

The block is armed by a software start. It begins counting at once, or it waits for a hardware start-of-cycle pulse. The excitation trigger follows the acquisition trigger after a programmable number of turns. A count of zero makes the two triggers coincide. In repeat mode a new acquisition trigger is prepared every programmed number of source ticks, until a software stop returns the block to idle. All tick and start inputs are single-cycle pulses that are already synchronous to `clk`.

Top module: `turn_trig_gen`

## Requirements
- R1: Delay and period counting uses `ms_tick` when `src_sel` is 0 and `turn_tick` when `src_sel` is 1.
- R2: With `defer_arm` 0, a `sw_start` accepted in cycle s starts counting: source ticks in cycles after s count toward `acq_delay`.
- R3: With `defer_arm` 1, a `sw_start` makes the block wait. A `cycle_start` in cycle s then starts counting exactly as in R2. A `cycle_start` while idle has no effect.
- R4: The delay expires in cycle e. This is the cycle of the `acq_delay`-th counted tick, or s+1 when `acq_delay` is 0. `acq_trig` fires in the first cycle that has `samp_en` high, at or after the first `turn_tick` in a cycle after e.
- R5: `acq_trig` and `exc_trig` are high only in cycles where `samp_en` is high. `acq_trig` is never high in two consecutive cycles.
- R6: If `exc_turns` is 0 when `acq_trig` fires, `exc_trig` fires in the same cycle. Otherwise `exc_trig` fires on the first `samp_en` at or after the `exc_turns`-th `turn_tick` after the acquisition cycle.
- R7: With `repeat_en` 0, each start yields exactly one acquisition trigger, and the block then returns to idle.
- R8: With `repeat_en` 1, the cycle of each acquisition trigger acts as s for the next one, and `repeat_period` is used in place of `acq_delay`.
- R9: `sw_stop` returns the block to idle from any state and cancels a pending excitation trigger. It wins over a `sw_start` in the same cycle.
- R10: A `sw_start` while the block is not idle is ignored.
- R11: While `rst_n` is low, both triggers stay low, and no start is remembered after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | Sampling clock enable |
| ms_tick | input | 1 | Millisecond timing pulse |
| turn_tick | input | 1 | Once-per-turn pulse |
| src_sel | input | 1 | Count source: 0 millisecond, 1 turn |
| defer_arm | input | 1 | 1: wait for start-of-cycle after arming |
| repeat_en | input | 1 | 1: re-fire every `repeat_period` ticks |
| sw_start | input | 1 | Software arm pulse |
| sw_stop | input | 1 | Software disarm pulse |
| cycle_start | input | 1 | Hardware start-of-cycle pulse |
| acq_delay | input | CNT_W | Source ticks before the first acquisition trigger |
| repeat_period | input | CNT_W | Source ticks between repeated triggers |
| exc_turns | input | CNT_W | Turns from acquisition to excitation trigger |
| acq_trig | output | 1 | Acquisition trigger pulse |
| exc_trig | output | 1 | Excitation trigger pulse |

## Verification
The assertions assume that the tick, start and stop inputs are already synchronous to `clk`. They also assume that the delay, period and turn-count inputs are stable from a start until the triggers they control have fired. The stimulus derives every tick and sample enable from fixed-period patterns of the cycle index. It sets all configuration before reset is released and holds it for the whole run. It only moves the start, stop and start-of-cycle pulses. The turn, millisecond and sample periods are chosen to cover both coincident and offset phases of `samp_en` against `turn_tick`.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
// Shared types for the turn-aligned trigger generator.
package trig_pkg;
    // Sequencer states: idle, waiting for start-of-cycle, counting delay, waiting for turn/sample alignment
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_COUNT = 2'd2,
        SEQ_ALIGN = 2'd3
    } seq_state_t;
endpackage

// File: rtl/tick_src_sel.sv
`timescale 1ns/1ps
// Picks the tick stream used for delay and period counting.
// Assumes both tick inputs are single-cycle pulses synchronous to clk.
module tick_src_sel (
    input  logic sel_i,
    input  logic ms_tick_i,
    input  logic turn_tick_i,
    output logic tick_o
);
    // Select turn ticks when sel_i is high, millisecond ticks otherwise
    always_comb begin
        tick_o = sel_i ? turn_tick_i : ms_tick_i;
    end
endmodule

// File: rtl/turn_aligner.sv
`timescale 1ns/1ps
// Fires once an alignment event has been seen while armed, on the first
// sample enable at or after that event. Remembers the event across cycles
// without a sample enable. Assumes arm_i drops or clr_i pulses between uses.
module turn_aligner (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clr_i,
    input  logic hit_i,
    input  logic samp_en_i,
    output logic fire_o
);
    logic seen_q;

    // Fire on a sample enable once the event is present now or was seen before
    always_comb begin
        fire_o = arm_i && samp_en_i && (seen_q || hit_i);
    end

    // Track an event that arrived while armed but before a sample enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (!arm_i || clr_i || fire_o) begin
            seen_q <= 1'b0;
        end else if (hit_i) begin
            seen_q <= 1'b1;
        end
    end

    // R5: a pulse only ever leaves on a sample enable
    a_r5_fire_on_samp: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> samp_en_i);

    // R4: the memory of an event only appears after an event while armed
    a_r4_seen_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen_q) |-> ($past(hit_i) && $past(arm_i)));
endmodule

// File: rtl/acq_sequencer.sv
`timescale 1ns/1ps
// Arming, delay counting and repeat control for the acquisition trigger.
// Assumes delay and period inputs are stable from a start until they are used.
module acq_sequencer
    import trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             turn_tick,
    input  logic             src_tick,
    input  logic             defer_arm,
    input  logic             repeat_en,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             cycle_start,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             acq_fire_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             in_align;
    logic             fire;

    assign in_align = (state_q == SEQ_ALIGN);

    turn_aligner u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (in_align),
        .clr_i     (1'b0),
        .hit_i     (turn_tick),
        .samp_en_i (samp_en),
        .fire_o    (fire)
    );

    assign acq_fire_o = fire;

    // Next-state and counter decisions, stop overriding everything
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            SEQ_IDLE: begin
                if (sw_start) begin
                    if (defer_arm) begin
                        state_d = SEQ_WAIT;
                    end else begin
                        state_d = SEQ_COUNT;
                        cnt_d   = delay_i;
                    end
                end
            end
            SEQ_WAIT: begin
                if (cycle_start) begin
                    state_d = SEQ_COUNT;
                    cnt_d   = delay_i;
                end
            end
            SEQ_COUNT: begin
                if (cnt_q == '0 || (src_tick && cnt_q == CNT_ONE)) begin
                    state_d = SEQ_ALIGN;
                    cnt_d   = '0;
                end else if (src_tick) begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            SEQ_ALIGN: begin
                if (fire) begin
                    if (repeat_en) begin
                        state_d = SEQ_COUNT;
                        cnt_d   = period_i;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
        if (sw_stop) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
        end
    end

    // State and delay counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R9: a stop always leaves the sequencer idle on the next cycle
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> (state_q == SEQ_IDLE));

    // R3: waiting persists until a start-of-cycle pulse or a stop
    a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && !cycle_start && !sw_stop) |=> (state_q == SEQ_WAIT));

    // R1: the delay count only moves on a selected source tick
    a_r1_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_COUNT && !src_tick && cnt_q != '0 && !sw_stop)
        |=> (state_q == SEQ_COUNT && $stable(cnt_q)));

    // R7: a one-shot trigger returns the sequencer to idle
    a_r7_oneshot_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !repeat_en && !sw_stop) |=> (state_q == SEQ_IDLE));

    // R10: a start while counting does not reload the count
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_COUNT && sw_start && !src_tick && cnt_q != '0 && !sw_stop)
        |=> $stable(cnt_q));
endmodule

// File: rtl/exc_follower.sv
`timescale 1ns/1ps
// Produces the excitation trigger a programmed number of turns after each
// acquisition trigger, realigned to turn tick and sample enable.
// A new launch replaces an excitation still pending.
module exc_follower #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             turn_tick,
    input  logic             sw_stop,
    input  logic             launch_i,
    input  logic [CNT_W-1:0] turns_i,
    output logic             exc_fire_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             pend_q;
    logic [CNT_W-1:0] left_q;
    logic             last_turn;
    logic             align_fire;
    logic             zero_now;

    assign last_turn = pend_q && turn_tick && (left_q == CNT_ONE);
    assign zero_now  = launch_i && (turns_i == '0);

    turn_aligner u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (pend_q),
        .clr_i     (launch_i),
        .hit_i     (last_turn),
        .samp_en_i (samp_en),
        .fire_o    (align_fire)
    );

    // Zero-turn launches pass straight through; others wait for alignment
    always_comb begin
        exc_fire_o = zero_now || align_fire;
    end

    // Pending flag and remaining turn count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            left_q <= '0;
        end else if (sw_stop) begin
            pend_q <= 1'b0;
            left_q <= '0;
        end else if (launch_i) begin
            pend_q <= (turns_i != '0);
            left_q <= turns_i;
        end else begin
            if (align_fire) begin
                pend_q <= 1'b0;
            end
            if (pend_q && turn_tick && left_q != '0) begin
                left_q <= left_q - CNT_ONE;
            end
        end
    end

    // R6: the remaining turn count only moves on a turn tick
    a_r6_turns_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !turn_tick && !launch_i && !sw_stop) |=> $stable(left_q));

    // R9: a stop cancels any pending excitation
    a_r9_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> !pend_q);
endmodule

// File: rtl/turn_trig_gen.sv
`timescale 1ns/1ps
// Turn-aligned acquisition and excitation trigger generator.
// Assumes all pulse inputs are single-cycle and synchronous to clk, and that
// the count inputs are held stable while a sequence runs.
module turn_trig_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             ms_tick,
    input  logic             turn_tick,
    input  logic             src_sel,
    input  logic             defer_arm,
    input  logic             repeat_en,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             cycle_start,
    input  logic [CNT_W-1:0] acq_delay,
    input  logic [CNT_W-1:0] repeat_period,
    input  logic [CNT_W-1:0] exc_turns,
    output logic             acq_trig,
    output logic             exc_trig
);
    logic src_tick;
    logic acq_fire;
    logic exc_fire;

    tick_src_sel u_src (
        .sel_i       (src_sel),
        .ms_tick_i   (ms_tick),
        .turn_tick_i (turn_tick),
        .tick_o      (src_tick)
    );

    acq_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_en     (samp_en),
        .turn_tick   (turn_tick),
        .src_tick    (src_tick),
        .defer_arm   (defer_arm),
        .repeat_en   (repeat_en),
        .sw_start    (sw_start),
        .sw_stop     (sw_stop),
        .cycle_start (cycle_start),
        .delay_i     (acq_delay),
        .period_i    (repeat_period),
        .acq_fire_o  (acq_fire)
    );

    exc_follower #(.CNT_W(CNT_W)) u_exc (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .turn_tick  (turn_tick),
        .sw_stop    (sw_stop),
        .launch_i   (acq_fire),
        .turns_i    (exc_turns),
        .exc_fire_o (exc_fire)
    );

    // Drive the trigger outputs, gated low while reset is held
    always_comb begin
        acq_trig = rst_n && acq_fire;
        exc_trig = rst_n && exc_fire;
    end

    // R5: acquisition pulses are one cycle wide
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acq_trig |=> !acq_trig);

    // R6: zero turns makes excitation coincide with acquisition
    a_r6_zero_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_trig && exc_turns == '0) |-> exc_trig);

    // R9: nothing fires in the cycle after a stop
    a_r9_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_stop) |-> (!acq_trig && !exc_trig));

    // R11: outputs stay low during reset
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!acq_trig && !exc_trig));
endmodule

// File: tb/turn_trig_gen_tb_top.sv
`timescale 1ns/1ps
module turn_trig_gen_tb_top;
    localparam int CNT_W = 16;
    localparam int NVEC  = 7;
    localparam int NCOL  = 11;
    // columns: src, defer, delay, exc_turns, period, repeat, turn_per, turn_ph, ms_per, samp_per, samp_ph
    localparam int VEC [NVEC][NCOL] = '{
        '{0, 0, 3, 0, 0, 0, 10, 3, 7, 1, 0},
        '{1, 0, 2, 2, 0, 0,  9, 4, 7, 3, 1},
        '{0, 1, 1, 1, 0, 0,  8, 0, 5, 4, 2},
        '{1, 1, 0, 3, 0, 0,  6, 5, 11, 2, 0},
        '{0, 0, 2, 0, 3, 1,  7, 2, 4, 3, 0},
        '{1, 0, 1, 1, 2, 1,  5, 1, 9, 5, 4},
        '{1, 0, 4, 0, 0, 1,  4, 0, 6, 4, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_en = 1'b0, ms_tick = 1'b0, turn_tick = 1'b0;
    logic src_sel = 1'b0, defer_arm = 1'b0, repeat_en = 1'b0;
    logic sw_start = 1'b0, sw_stop = 1'b0, cycle_start = 1'b0;
    logic [CNT_W-1:0] acq_delay = '0, repeat_period = '0, exc_turns = '0;
    logic acq_trig, exc_trig;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int g_tp = 10, g_tph = 0, g_mp = 7, g_sp = 1, g_sph = 0;
    int acq_n, exc_n, bad_q;
    int acq_c [8];
    int exc_c [8];

    always #5 clk = ~clk;

    turn_trig_gen #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .ms_tick(ms_tick),
        .turn_tick(turn_tick), .src_sel(src_sel), .defer_arm(defer_arm),
        .repeat_en(repeat_en), .sw_start(sw_start), .sw_stop(sw_stop),
        .cycle_start(cycle_start), .acq_delay(acq_delay),
        .repeat_period(repeat_period), .exc_turns(exc_turns),
        .acq_trig(acq_trig), .exc_trig(exc_trig)
    );

    function automatic bit turn_at(int k); return (k % g_tp) == g_tph; endfunction
    function automatic bit ms_at(int k);   return k > 0 && (k % g_mp) == 0; endfunction
    function automatic bit se_at(int k);   return (k % g_sp) == g_sph; endfunction
    function automatic bit src_at(int k, int src); return src != 0 ? turn_at(k) : ms_at(k); endfunction

    // Expected acquisition cycle from the requirement-level timing rules (R4)
    function automatic int exp_acq(int s, int d, int src);
        int e = s + 1;
        int c;
        if (d > 0) begin
            int n = 0;
            c = s + 1;
            while (n < d) begin
                if (src_at(c, src)) n++;
                if (n < d) c++;
            end
            e = c;
        end
        c = e + 1;
        while (!turn_at(c)) c++;
        while (!se_at(c)) c++;
        return c;
    endfunction

    // Expected excitation cycle (R6)
    function automatic int exp_exc(int f, int t);
        int c = f;
        int n = 0;
        if (t == 0) return f;
        while (n < t) begin
            c++;
            if (turn_at(c)) n++;
        end
        while (!se_at(c)) c++;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset, then drive one scenario cycle by cycle and record trigger cycles
    task automatic run_case(input int src, input int dfr, input int d, input int e,
                            input int p, input int rep, input int start_c,
                            input int start2_c, input int cs_c, input int stop_c,
                            input int ncyc);
        acq_n = 0; exc_n = 0; bad_q = 0;
        @(negedge clk);
        rst_n = 1'b0;
        samp_en = 0; ms_tick = 0; turn_tick = 0;
        sw_start = 0; sw_stop = 0; cycle_start = 0;
        src_sel = src[0]; defer_arm = dfr[0]; repeat_en = rep[0];
        acq_delay = CNT_W'(d); exc_turns = CNT_W'(e); repeat_period = CNT_W'(p);
        @(negedge clk);
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            rst_n       = 1'b1;
            samp_en     = se_at(k);
            turn_tick   = turn_at(k);
            ms_tick     = ms_at(k);
            sw_start    = (k == start_c) || (k == start2_c);
            sw_stop     = (k == stop_c);
            cycle_start = (cs_c >= 0) && (k == cs_c || k == 1);
            #4;
            if (acq_trig) begin
                if (acq_n < 8) acq_c[acq_n] = k;
                acq_n++;
            end
            if (exc_trig) begin
                if (exc_n < 8) exc_c[exc_n] = k;
                exc_n++;
            end
            if ((acq_trig || exc_trig) && !samp_en) bad_q++;
        end
        @(negedge clk);
        samp_en = 0; turn_tick = 0; ms_tick = 0; sw_start = 0; sw_stop = 0; cycle_start = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Table-driven scenarios
        for (int v = 0; v < NVEC; v++) begin
            int s, f1, f2, x1;
            g_tp = VEC[v][6]; g_tph = VEC[v][7]; g_mp = VEC[v][8];
            g_sp = VEC[v][9]; g_sph = VEC[v][10];
            s  = (VEC[v][1] != 0) ? 8 : 2;
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                     2, -1, (VEC[v][1] != 0) ? 8 : -1, -1, 160);
            f1 = exp_acq(s, VEC[v][2], VEC[v][0]);
            x1 = exp_exc(f1, VEC[v][3]);
            // R1 R4 with R2 (immediate) or R3 (deferred)
            check(acq_n > 0 && acq_c[0] == f1,
                  (VEC[v][1] != 0) ? "R1 R3 R4 first acquisition" : "R1 R2 R4 first acquisition",
                  acq_n > 0 ? acq_c[0] : -1, f1);
            check(exc_n > 0 && exc_c[0] == x1, "R6 first excitation",
                  exc_n > 0 ? exc_c[0] : -1, x1);
            check(bad_q == 0, "R5 pulse without sample enable", bad_q, 0);
            if (VEC[v][5] != 0) begin
                f2 = exp_acq(f1, VEC[v][4], VEC[v][0]);
                check(acq_n > 1 && acq_c[1] == f2, "R8 repeated acquisition",
                      acq_n > 1 ? acq_c[1] : -1, f2);
            end else begin
                check(acq_n == 1, "R7 single acquisition count", acq_n, 1);
            end
        end

        // R11: outputs low while reset held with active inputs
        g_tp = 10; g_tph = 0; g_mp = 7; g_sp = 1; g_sph = 0;
        begin
            int hits = 0;
            @(negedge clk);
            rst_n = 0; samp_en = 1; turn_tick = 1; sw_start = 1; defer_arm = 0;
            acq_delay = '0; exc_turns = '0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                #4;
                if (acq_trig || exc_trig) hits++;
            end
            check(hits == 0, "R11 triggers during reset", hits, 0);
        end
        // R11: no start remembered; R3: start-of-cycle while idle ignored
        run_case(1, 1, 0, 0, 0, 0, -1, -1, 10, -1, 80);
        check(acq_n == 0 && exc_n == 0, "R3 R11 idle start-of-cycle ignored", acq_n + exc_n, 0);

        // R9: stop during delay count
        run_case(1, 0, 5, 0, 0, 0, 2, -1, -1, 20, 120);
        check(acq_n == 0, "R9 stop during count", acq_n, 0);
        // R9: stop wins over start in the same cycle
        run_case(1, 0, 0, 0, 0, 0, 2, -1, -1, 2, 60);
        check(acq_n == 0, "R9 stop beats start", acq_n, 0);
        // R9: stop cancels a pending excitation
        run_case(1, 0, 0, 3, 0, 0, 2, -1, -1, 12, 80);
        check(acq_n == 1 && acq_c[0] == 10, "R9 acquisition before stop",
              acq_n > 0 ? acq_c[0] : -1, 10);
        check(exc_n == 0, "R9 excitation cancelled", exc_n, 0);
        // R9 R8: stop ends a repeat sequence
        run_case(1, 0, 0, 0, 1, 1, 2, -1, -1, 35, 120);
        check(acq_n == 2, "R9 R8 repeat stopped", acq_n, 2);
        // R10: second start while counting ignored
        run_case(1, 0, 3, 0, 0, 0, 2, 15, -1, -1, 80);
        check(acq_n == 1 && acq_c[0] == exp_acq(2, 3, 1), "R10 restart ignored",
              acq_n > 0 ? acq_c[0] : -1, exp_acq(2, 3, 1));

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule